// File: doc/BRIEF.md
# SIMD Compare and Select Unit

This unit is a 128-bit data-parallel datapath. It provides branch-free conditional assignment. A compare operation splits two 128-bit operands into lanes of 8, 16 or 32 bits and tests each lane for equality, signed greater-than or unsigned greater-than. Each lane of the result is a mask as wide as the element: all ones when the condition holds and all zeros when it does not.

A select operation takes such a mask and merges two sources bit by bit. Wherever the mask bit is one, the bit comes from the first source; elsewhere it comes from the second. The unit has no less-than or not-equal compare. Software gets less-than by swapping the operands and not-equal by inverting the equality mask.

Operations enter with a valid strobe and return registered, one cycle later. Byte lane 0 is the most significant byte of the vector, so lane k of width W occupies bits [127-k*W -: W].

Top module: `simd_cmp_sel`

## Requirements
- R1: While rst_ni is low and after its release, valid_o is 0 and res_o is all zeros until the first accepted operation.
- R2: An operation presented with valid_i high produces valid_o high and its result on res_o at the next rising clock edge. When valid_i is low, valid_o falls and res_o holds its previous value, whatever the other inputs carry.
- R3: With op_i = 0 (equality), each lane field of res_o is all ones when the a_i and b_i lanes are bit-identical, and all zeros otherwise.
- R4: With op_i = 1 (signed greater-than), each lane field is all ones when the a_i lane, read as two's complement with its top bit as sign, exceeds the b_i lane. For example, 0x7F > 0x80 holds at 8 bits.
- R5: With op_i = 2 (unsigned greater-than), each lane field is all ones when the a_i lane, read as an unsigned number, exceeds the b_i lane. For example, 0x80 > 0x7F holds at 8 bits.
- R6: For compares, elem_i selects the lane width: 0 gives 16 lanes of 8 bits, 1 gives 8 lanes of 16 bits, 2 gives 4 lanes of 32 bits, and 3 acts as 2. Every field of res_o is uniformly all ones or all zeros.
- R7: Lanes are independent. A difference confined to one lane affects only that lane's field, including a difference in the lane's least significant byte.
- R8: With op_i = 3 (select), res_o = (m_i & a_i) | (~m_i & b_i) bit by bit, and elem_i has no effect.
- R9: Derived conditions are consistent. For any operands, exactly one of eq(a,b), gt(a,b) and gt(b,a) is set in each lane, for both signed and unsigned greater-than. The inverse of eq(a,b) equals the not-equal condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 0 equal, 1 signed greater-than, 2 unsigned greater-than, 3 select |
| elem_i | input | 2 | Lane width for compares: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits |
| a_i | input | 128 | First operand or first select source |
| b_i | input | 128 | Second operand or second select source |
| m_i | input | 128 | Select mask, where 1 picks a_i |
| valid_o | output | 1 | Result valid |
| res_o | output | 128 | Compare mask or select result |

## Verification
At 8 bits, the bench runs every one of the 65,536 operand pairs through all three compares. A design that lets the sign bit into the unsigned compare fails there, and so does one that treats signed and unsigned alike. Wider lanes are tested with boundary values: zero, one, the signed minimum and maximum, all ones, and their neighbours. A merge that sent the wrong byte's result up the chain would get minimum against maximum wrong or would corrupt a low-byte-only difference.

Further tests cover the rest of the behaviour. A lane-isolation pattern and random vectors catch masks that spill across lanes or sit at the wrong width. Swapped-operand trios catch a compare that is not strict or not exclusive. Random selects with arbitrary elem_i catch a select that depends on width, and an idle cycle with busy inputs catches a result register that does not hold.

// File: rtl/simd_cs_pkg.sv
package simd_cs_pkg;
  typedef enum logic [1:0] {
    OP_EQ  = 2'd0,
    OP_GTS = 2'd1,
    OP_GTU = 2'd2,
    OP_SEL = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    EW_8   = 2'd0,
    EW_16  = 2'd1,
    EW_32  = 2'd2,
    EW_32X = 2'd3
  } elem_w_e;

  typedef struct packed {
    logic eq;
    logic gts;
    logic gtu;
  } cmp_flags_t;

  // combine a more significant chunk with a less significant one
  function automatic cmp_flags_t merge_flags(cmp_flags_t hi, cmp_flags_t lo);
    cmp_flags_t r;
    r.eq  = hi.eq & lo.eq;
    r.gtu = hi.gtu | (hi.eq & lo.gtu);
    r.gts = hi.gts | (hi.eq & lo.gtu);
    return r;
  endfunction

  function automatic logic pick_flag(cmp_flags_t f, op_kind_e k);
    logic r;
    case (k)
      OP_EQ:   r = f.eq;
      OP_GTS:  r = f.gts;
      OP_GTU:  r = f.gtu;
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/simd_byte_cmp.sv
module simd_byte_cmp
  import simd_cs_pkg::*;
#(
  parameter int unsigned NB = 16
) (
  input  logic [NB*8-1:0]       a_i,
  input  logic [NB*8-1:0]       b_i,
  output cmp_flags_t [NB-1:0]   flags_o
);
  // byte 0 is the most significant byte
  for (genvar gi = 0; gi < NB; gi++) begin : g_byte
    logic [7:0] ab, bb;
    assign ab = a_i[NB*8-1-8*gi -: 8];
    assign bb = b_i[NB*8-1-8*gi -: 8];
    assign flags_o[gi].eq  = (ab == bb);
    assign flags_o[gi].gtu = (ab > bb);
    assign flags_o[gi].gts = ($signed(ab) > $signed(bb));
  end
endmodule

// File: rtl/simd_lane_merge.sv
module simd_lane_merge
  import simd_cs_pkg::*;
#(
  parameter int unsigned NB = 16,
  localparam int unsigned N16 = NB / 2,
  localparam int unsigned N32 = NB / 4
) (
  input  cmp_flags_t [NB-1:0] byte_f_i,
  input  op_kind_e            kind_i,
  output logic [NB-1:0]       hit8_o,
  output logic [N16-1:0]      hit16_o,
  output logic [N32-1:0]      hit32_o
);
  cmp_flags_t [N16-1:0] f16;
  cmp_flags_t [N32-1:0] f32;

  for (genvar gi = 0; gi < NB; gi++) begin : g_h8
    assign hit8_o[gi] = pick_flag(byte_f_i[gi], kind_i);
  end

  for (genvar gj = 0; gj < N16; gj++) begin : g_h16
    assign f16[gj]     = merge_flags(byte_f_i[2*gj], byte_f_i[2*gj+1]);
    assign hit16_o[gj] = pick_flag(f16[gj], kind_i);
  end

  for (genvar gk = 0; gk < N32; gk++) begin : g_h32
    assign f32[gk]     = merge_flags(f16[2*gk], f16[2*gk+1]);
    assign hit32_o[gk] = pick_flag(f32[gk], kind_i);
  end
endmodule

// File: rtl/simd_mask_expand.sv
module simd_mask_expand
  import simd_cs_pkg::*;
#(
  parameter int unsigned NB = 16,
  localparam int unsigned N16 = NB / 2,
  localparam int unsigned N32 = NB / 4
) (
  input  logic [NB-1:0]   hit8_i,
  input  logic [N16-1:0]  hit16_i,
  input  logic [N32-1:0]  hit32_i,
  input  elem_w_e         elem_i,
  output logic [NB*8-1:0] mask_o
);
  for (genvar gi = 0; gi < NB; gi++) begin : g_fill
    logic sel;
    always_comb begin
      case (elem_i)
        EW_8:    sel = hit8_i[gi];
        EW_16:   sel = hit16_i[gi/2];
        default: sel = hit32_i[gi/4];
      endcase
    end
    assign mask_o[NB*8-1-8*gi -: 8] = {8{sel}};
  end
endmodule

// File: rtl/simd_bit_select.sv
module simd_bit_select #(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] m_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] y_o
);
  assign y_o = (m_i & a_i) | (~m_i & b_i);
endmodule

// File: rtl/simd_cmp_sel.sv
module simd_cmp_sel
  import simd_cs_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned NB  = VEC_W / 8,
  localparam int unsigned N16 = NB / 2,
  localparam int unsigned N32 = NB / 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [1:0]       elem_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic [VEC_W-1:0] m_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o
);
  op_kind_e             kind;
  elem_w_e              elem;
  cmp_flags_t [NB-1:0]  byte_f;
  logic [NB-1:0]        hit8;
  logic [N16-1:0]       hit16;
  logic [N32-1:0]       hit32;
  logic [VEC_W-1:0]     cmp_mask;
  logic [VEC_W-1:0]     sel_res;
  logic [VEC_W-1:0]     res_d;

  assign kind = op_kind_e'(op_i);
  assign elem = elem_w_e'(elem_i);

  simd_byte_cmp #(.NB(NB)) u_byte_cmp (
    .a_i(a_i), .b_i(b_i), .flags_o(byte_f)
  );

  simd_lane_merge #(.NB(NB)) u_merge (
    .byte_f_i(byte_f), .kind_i(kind),
    .hit8_o(hit8), .hit16_o(hit16), .hit32_o(hit32)
  );

  simd_mask_expand #(.NB(NB)) u_expand (
    .hit8_i(hit8), .hit16_i(hit16), .hit32_i(hit32),
    .elem_i(elem), .mask_o(cmp_mask)
  );

  simd_bit_select #(.VEC_W(VEC_W)) u_select (
    .m_i(m_i), .a_i(a_i), .b_i(b_i), .y_o(sel_res)
  );

  assign res_d = (kind == OP_SEL) ? sel_res : cmp_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end

  // R2 latency and hold
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));

  // R3 identical operands compare equal in every lane
  a_r3_eq_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind == OP_EQ && a_i == b_i) |=> (res_o == '1));

  // R4/R5 greater-than is strict
  a_r4_r5_gt_strict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (kind == OP_GTS || kind == OP_GTU) && a_i == b_i) |=> (res_o == '0));

  // R8 select is bitwise
  a_r8_select_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind == OP_SEL) |=>
      (res_o == (($past(m_i) & $past(a_i)) | (~$past(m_i) & $past(b_i)))));

  // R6 fields uniform at the chosen width
  for (genvar gi = 0; gi < NB; gi++) begin : g_a_byte
    a_r6_byte_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_mask[VEC_W-1-8*gi -: 8] == 8'h00) || (cmp_mask[VEC_W-1-8*gi -: 8] == 8'hFF));
  end
  for (genvar gj = 0; gj < N16; gj++) begin : g_a_f16
    a_r6_field16: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elem != EW_8) |->
        (cmp_mask[VEC_W-1-16*gj -: 8] == cmp_mask[VEC_W-9-16*gj -: 8]));
  end
  for (genvar gk = 0; gk < N32; gk++) begin : g_a_f32
    a_r6_field32: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elem == EW_32 || elem == EW_32X) |->
        (cmp_mask[VEC_W-1-32*gk -: 16] == cmp_mask[VEC_W-17-32*gk -: 16]));
  end
endmodule

// File: tb/simd_cmp_sel_tb_top.sv
module simd_cmp_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   op_i = 2'd0;
  logic [1:0]   elem_i = 2'd0;
  logic [127:0] a_i = '0, b_i = '0, m_i = '0;
  logic         valid_o;
  logic [127:0] res_o;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_cmp_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .elem_i(elem_i),
    .a_i(a_i), .b_i(b_i), .m_i(m_i), .valid_o(valid_o), .res_o(res_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int width_of(input int wc);
    return (wc == 0) ? 8 : (wc == 1) ? 16 : 32;
  endfunction

  // kind: 0 eq, 1 signed gt, 2 unsigned gt
  function automatic logic [127:0] exp_cmp(input int kind, input int wc,
                                           input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    int w = width_of(wc);
    longint msk = (64'd1 << w) - 1;
    for (int k = 0; k < 128 / w; k++) begin
      int sh = 128 - (k + 1) * w;
      logic [127:0] ta = a >> sh;
      logic [127:0] tb = b >> sh;
      longint ua = longint'(ta[31:0]) & msk;
      longint ub = longint'(tb[31:0]) & msk;
      longint sa = ua[w-1] ? ua - (64'd1 << w) : ua;
      longint sb = ub[w-1] ? ub - (64'd1 << w) : ub;
      bit hit = (kind == 0) ? (ua == ub) : (kind == 1) ? (sa > sb) : (ua > ub);
      if (hit) r = r | ({64'd0, msk} << sh);
    end
    return r;
  endfunction

  task automatic run_op(input int op, input int wc, input logic [127:0] a,
                        input logic [127:0] b, input logic [127:0] m,
                        output logic [127:0] r);
    @(negedge clk);
    valid_i = 1'b1; op_i = op[1:0]; elem_i = wc[1:0]; a_i = a; b_i = b; m_i = m;
    @(negedge clk);
    r = res_o;
    valid_i = 1'b0;
  endtask

  task automatic cmp_chk(input string req, input int kind, input int wc,
                         input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    run_op(kind, wc, a, b, '0, r);
    chk(req, r, exp_cmp(kind, wc, a, b));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  logic [31:0] bvals [8];

  initial begin
    logic [127:0] r, r1, r2, r3, va, vb;
    bvals[0] = 32'h0000_0000; bvals[1] = 32'h0000_0001;
    bvals[2] = 32'h7FFF_FFFF; bvals[3] = 32'h8000_0000;
    bvals[4] = 32'hFFFF_FFFF; bvals[5] = 32'h8000_0001;
    bvals[6] = 32'h7FFF_FFFE; bvals[7] = 32'h0000_00FF;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 valid_o in reset", {127'd0, valid_o}, '0);
    chk("R1 res_o in reset", res_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid_o after release", {127'd0, valid_o}, '0);
    chk("R1 res_o after release", res_o, '0);

    // R2 latency
    @(negedge clk);
    valid_i = 1'b1; op_i = 2'd0; elem_i = 2'd0; a_i = '1; b_i = '1;
    chk("R2 no early result", {127'd0, valid_o}, '0);
    @(negedge clk);
    chk("R2 valid_o one cycle later", {127'd0, valid_o}, 128'd1);
    chk("R2 result one cycle later", res_o, '1);
    // R2 hold while idle with busy inputs
    valid_i = 1'b0; op_i = 2'd3; a_i = '0; b_i = '0; m_i = '0;
    @(negedge clk);
    chk("R2 valid_o drops", {127'd0, valid_o}, '0);
    chk("R2 result held when idle", res_o, '1);
    @(negedge clk);
    chk("R2 result still held", res_o, '1);

    // R3 R4 R5 exhaustive 8-bit sweep
    for (int kind = 0; kind < 3; kind++) begin
      for (int av = 0; av < 256; av++) begin
        for (int g = 0; g < 16; g++) begin
          va = '0; vb = '0;
          for (int j = 0; j < 16; j++) begin
            va[127-8*j -: 8] = av[7:0];
            vb[127-8*j -: 8] = 8'(g * 16 + j);
          end
          cmp_chk(kind == 0 ? "R3 eq w8" : kind == 1 ? "R4 gts w8" : "R5 gtu w8",
                  kind, 0, va, vb);
        end
      end
    end

    // R6 boundary values at 16 and 32 bits (elem 3 too)
    for (int kind = 0; kind < 3; kind++) begin
      for (int i = 0; i < 8; i++) begin
        va = '0; vb = '0;
        for (int j = 0; j < 8; j++) begin
          va[127-16*j -: 16] = {bvals[i][31], bvals[i][14:0]};
          vb[127-16*j -: 16] = {bvals[j][31], bvals[j][14:0]};
        end
        cmp_chk("R6 boundary w16", kind, 1, va, vb);
        for (int h = 0; h < 2; h++) begin
          for (int j = 0; j < 4; j++) begin
            va[127-32*j -: 32] = bvals[i];
            vb[127-32*j -: 32] = bvals[h*4+j];
          end
          cmp_chk("R6 boundary w32", kind, 2, va, vb);
          cmp_chk("R6 boundary w32 code3", kind, 3, va, vb);
        end
      end
    end

    // R4 R5 min vs max explicit
    va = {4{32'h8000_0000}}; vb = {4{32'h7FFF_FFFF}};
    run_op(1, 2, va, vb, '0, r);
    chk("R4 min gt max signed", r, '0);
    run_op(2, 2, va, vb, '0, r);
    chk("R5 min gt max unsigned", r, '1);

    // R7 lane isolation: only low byte of lane 2 differs
    va = {4{32'h1234_5678}}; vb = va; va[127-64-24 -: 8] = 8'h79;
    run_op(2, 2, va, vb, '0, r);
    chk("R7 single lane gtu w32", r, {32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0});
    run_op(0, 1, va, vb, '0, r);
    chk("R7 single lane eq w16", r, {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF,
                                     16'hFFFF, 16'h0, 16'hFFFF, 16'hFFFF});

    // R6 random sweep all widths
    for (int n = 0; n < 600; n++) begin
      va = rnd128(); vb = rnd128();
      if (n % 3 == 0) vb = va ^ {4{32'h0000_0100}};
      cmp_chk("R6 random", n % 3, (n / 3) % 4, va, vb);
    end

    // R8 select, elem ignored
    for (int n = 0; n < 200; n++) begin
      logic [127:0] mm;
      va = rnd128(); vb = rnd128(); mm = rnd128();
      run_op(3, n % 4, va, vb, mm, r);
      chk("R8 select bitwise", r, (mm & va) | (~mm & vb));
    end

    // R9 derived conditions
    for (int n = 0; n < 150; n++) begin
      int wc = n % 3;
      int gk = 1 + (n / 3) % 2;
      va = rnd128(); vb = rnd128();
      if (n % 5 == 0) vb = va;
      run_op(0, wc, va, vb, '0, r1);
      run_op(gk, wc, va, vb, '0, r2);
      run_op(gk, wc, vb, va, '0, r3);
      chk("R9 trio covers all", r1 | r2 | r3, '1);
      chk("R9 trio exclusive", (r1 & r2) | (r1 & r3) | (r2 & r3), '0);
      chk("R9 swapped is less-than", r3, exp_cmp(gk, wc, vb, va));
      chk("R9 inverted eq is ne", ~r1, ~exp_cmp(0, wc, va, vb));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule